// File: doc/BRIEF.md
# MII transmit frame serializer

This block sits between a byte-wide streaming frame source and a 4-bit MII transmit port. A source offers one byte at a time through valid, data, last and an error mark. The block then produces a complete transmit burst. The burst opens with a run of preamble nibbles, follows with the start-of-frame delimiter, and then sends each payload byte as two nibbles, the least significant nibble first. The transmit-enable output frames the whole burst, and the transmit-error output marks any nibble that should carry an error pattern on the line.

The block paces the source itself. It asks for a byte once every two clocks, in the clock before that byte's low nibble goes onto the bus. It never stalls the wire: if no byte is offered when one is due, the slot is filled with an error-marked nibble pair. The block counts the bytes of each frame against a minimum and a maximum length. A violation is reported on a flag, and the affected nibbles are error-marked, but the frame is always closed in an orderly way. Between frames the block keeps transmit-enable low for a fixed minimum number of clocks.

Top module: `mii_tx_serializer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous, active low), the block returns to idle. After that edge `tx_en`, `tx_er`, `txd`, `s_ready` and `len_err` are all 0, even when the reset interrupts a frame.
- R2: A frame starts with exactly 15 nibbles of value 4'h5, with `tx_en` high and `tx_er` low. `txd[0]` carries the earliest bit.
- R3: The nibble right after the preamble is the delimiter, 4'hD, with `tx_en` high.
- R4: Each payload byte appears as two consecutive nibbles after the delimiter. Bits 3:0 come first and bits 7:4 come second, in the order the bytes were accepted.
- R5: For a frame whose payload occupies W byte slots, `tx_en` is high for exactly 16 + 2·W consecutive clocks. It is low at every other time, and while it is low `txd` is 0 and `tx_er` is 0.
- R6: `s_ready` is high only in the clock that shows the delimiter and in the clock that shows the high nibble of a byte that was not marked last. A byte moves at the rising edge that ends a clock in which both `s_ready` and `s_valid` are high. `s_ready` is never high in two consecutive clocks.
- R7: A byte offered with `s_err` high is sent with its normal nibbles, and `tx_er` is high on both of them. Bytes without the mark and within the length limits have `tx_er` low.
- R8: If `s_valid` is low while `s_ready` is high inside a frame, that byte slot is still sent as a nibble pair of value 0 with `tx_er` high. The frame then continues, and the slot counts towards the frame length.
- R9: If a frame ends after fewer than `MIN_LEN` byte slots (default 64), both nibbles of its last byte carry `tx_er`. `len_err` goes high from that byte's first nibble and stays high until the first preamble nibble of the next frame. A frame of exactly `MIN_LEN` slots raises neither.
- R10: Every byte slot after slot `MAX_LEN` (default 1518) carries `tx_er` on both nibbles, and `len_err` is raised and held as in R9. The frame still ends only after the byte marked last. A frame of exactly `MAX_LEN` slots raises neither.
- R11: Between the end of one frame and the start of the next, `tx_en` stays low for at least `IFG_CLKS` clocks (default 24). If the source holds a new byte valid throughout, the gap is exactly `IFG_CLKS` clocks.
- R12: While `s_valid` is low in idle, no frame starts, `tx_en` stays low and `s_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Source offers a byte |
| s_data | input | 8 | Offered byte |
| s_err | input | 1 | Offered byte is to be sent error-marked |
| s_last | input | 1 | Offered byte ends the frame |
| s_ready | output | 1 | Block takes the offered byte at the next rising edge |
| txd | output | 4 | Transmit nibble, bit 0 earliest on the line |
| tx_en | output | 1 | Transmit enable, high for the whole burst |
| tx_er | output | 1 | Transmit error for the current nibble |
| len_err | output | 1 | Current or most recent frame broke the length limits |

## Verification
The assertions make no assumption about the source. `s_valid`, `s_err` and `s_last` may change in any clock, because `s_ready` depends only on the block's own state and a missing byte becomes an error slot. The gap property relies only on reset being synchronous, so the first frame after reset is not held to the gap. The bench changes the source inputs only at falling edges. It offers a new frame only after the previous one has been taken completely, except in the back-to-back case, where it deliberately holds the next first byte valid so that the exact gap can be measured.

// File: rtl/mii_tx_pkg.sv
// Shared definitions of the MII transmit serializer.
// Holds the sequencer states and the fixed nibble codes of the burst header.
package mii_tx_pkg;

    // Sequencer states; each names what the output register shows.
    typedef enum logic [2:0] {
        ST_IDLE,   // tx_en low
        ST_PRE,    // a preamble nibble
        ST_SFD,    // the delimiter nibble
        ST_LO,     // low nibble of a byte
        ST_HI      // high nibble of a byte
    } txst_e;

    localparam int        PRE_NIBBLES = 15;
    localparam logic [3:0] NIB_PRE    = 4'h5;
    localparam logic [3:0] NIB_SFD    = 4'hD;

endpackage

// File: rtl/mii_tx_len_check.sv
// Per-frame byte-slot counter and length judge.
// Assumes 1 <= MIN_LEN <= MAX_LEN. The counter saturates at MAX_LEN, so once
// a frame is over length every later slot is judged bad as well.
module mii_tx_len_check #(
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,      // frame starts
    input  logic take,       // a byte slot is consumed this clock
    input  logic is_last,    // consumed slot ends the frame
    output logic bad         // consumed slot breaks the length rules
);
    localparam int CW = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] MAX_C  = CW'(MAX_LEN);
    localparam logic [CW-1:0] MINM1  = CW'(MIN_LEN - 1);

    logic [CW-1:0] count;

    // Count consumed slots of the current frame, saturating at MAX_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (take && count < MAX_C)
            count <= count + 1'b1;
    end

    // Judge the slot being consumed: beyond the maximum, or a short last one.
    always_comb begin
        bad = take && ((count >= MAX_C) || (is_last && count < MINM1));
    end

endmodule

// File: rtl/mii_tx_gap_timer.sv
// Minimum idle timer between frames.
// Loaded when the last nibble of a frame leaves. Reports done once IFG_CLKS
// idle clocks have passed since the load. Assumes IFG_CLKS >= 1.
module mii_tx_gap_timer #(
    parameter int IFG_CLKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int GW = $clog2(IFG_CLKS + 1);
    localparam logic [GW-1:0] START = GW'(IFG_CLKS - 1);

    logic [GW-1:0] cnt;

    // Count down the remaining idle clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= START;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // The gap is over when the count is exhausted.
    always_comb begin
        done = (cnt == '0);
    end

endmodule

// File: rtl/mii_tx_serializer.sv
// Byte stream to MII transmit nibble serializer.
// Emits preamble, delimiter and payload nibbles (low nibble first) with
// registered txd/tx_en/tx_er. Requests one byte per two clocks and never
// stalls the wire: a missing byte becomes an error-marked zero slot.
// Assumes the source's inputs are synchronous to clk.
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int MIN_LEN  = 64,
    parameter int MAX_LEN  = 1518,
    parameter int IFG_CLKS = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_err,
    input  logic       s_last,
    output logic       s_ready,
    output logic [3:0] txd,
    output logic       tx_en,
    output logic       tx_er,
    output logic       len_err
);
    localparam int PW = $clog2(PRE_NIBBLES + 1);
    localparam logic [PW-1:0] PRE_END = PW'(PRE_NIBBLES);

    txst_e         state;
    logic [PW-1:0] pcnt;
    logic [3:0]    hi_nib;
    logic          cur_err;
    logic          cur_last;
    logic          gap_done;
    logic          len_bad;
    logic          start;
    logic          slot_err;
    logic          slot_last;
    logic [7:0]    slot_data;

    // Slot request and the contents of the slot being consumed.
    always_comb begin
        s_ready   = (state == ST_SFD) || (state == ST_HI && !cur_last);
        start     = (state == ST_IDLE) && s_valid && gap_done;
        slot_data = s_valid ? s_data : 8'h00;
        slot_last = s_valid && s_last;
        slot_err  = !s_valid || s_err || len_bad;
    end

    mii_tx_len_check #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .take    (s_ready),
        .is_last (slot_last),
        .bad     (len_bad)
    );

    mii_tx_gap_timer #(
        .IFG_CLKS (IFG_CLKS)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_HI && cur_last),
        .done  (gap_done)
    );

    // Sequencer and registered MII outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pcnt     <= '0;
            hi_nib   <= '0;
            cur_err  <= 1'b0;
            cur_last <= 1'b0;
            txd      <= '0;
            tx_en    <= 1'b0;
            tx_er    <= 1'b0;
            len_err  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_PRE;
                        pcnt    <= PW'(1);
                        txd     <= NIB_PRE;
                        tx_en   <= 1'b1;
                        tx_er   <= 1'b0;
                        len_err <= 1'b0;
                    end
                end
                ST_PRE: begin
                    if (pcnt == PRE_END) begin
                        state <= ST_SFD;
                        txd   <= NIB_SFD;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                        txd  <= NIB_PRE;
                    end
                end
                ST_LO: begin
                    state <= ST_HI;
                    txd   <= hi_nib;
                    tx_er <= cur_err;
                end
                ST_SFD, ST_HI: begin
                    if (state == ST_HI && cur_last) begin
                        state <= ST_IDLE;
                        txd   <= '0;
                        tx_en <= 1'b0;
                        tx_er <= 1'b0;
                    end else begin
                        state    <= ST_LO;
                        txd      <= slot_data[3:0];
                        hi_nib   <= slot_data[7:4];
                        tx_er    <= slot_err;
                        cur_err  <= slot_err;
                        cur_last <= slot_last;
                        if (len_bad)
                            len_err <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mii_tx_serializer_chk.sv
// Property checker for the MII transmit serializer, attached by bind.
// Tracks the length of each idle run to check the minimum gap.
module mii_tx_serializer_chk #(
    parameter int IFG_CLKS = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready,
    input logic [3:0] txd,
    input logic       tx_en,
    input logic       tx_er,
    input logic       len_err
);
    localparam int LW = $clog2(IFG_CLKS + 1);

    logic [LW-1:0] low_cnt;
    logic          seen_frame;

    // Length of the current idle run (saturating) and whether a frame has ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (tx_en) begin
                low_cnt    <= '0;
                seen_frame <= 1'b1;
            end else if (low_cnt < LW'(IFG_CLKS)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_frame && $rose(tx_en)) |-> (low_cnt >= LW'(IFG_CLKS))); // R11

    AST_FIRST_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 4'h5 && !tx_er)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 4'h0 && !tx_er && !s_ready)); // R5

    AST_READY_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready); // R6

    AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> tx_en); // R6

    AST_ER_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        tx_er |-> tx_en); // R7

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> (len_err || $rose(tx_en))); // R9

endmodule

bind mii_tx_serializer mii_tx_serializer_chk #(
    .IFG_CLKS (IFG_CLKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .txd     (txd),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .len_err (len_err)
);

// File: tb/mii_tx_serializer_bench.sv
// Self-checking bench: logs every output at falling edges, then compares each
// burst against a nibble image computed from the requirements.
module mii_tx_serializer_bench;
    localparam int MINL = 4;
    localparam int MAXL = 8;
    localparam int IFG  = 24;
    localparam int LOGN = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_err = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic [3:0] txd;
    logic       tx_en;
    logic       tx_er;
    logic       len_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_end = 0;
    int prev_end = -1;

    logic       lg_en  [LOGN];
    logic [3:0] lg_d   [LOGN];
    logic       lg_er  [LOGN];
    logic       lg_rdy [LOGN];
    logic       lg_len [LOGN];
    logic [7:0] exp_b  [64];
    logic       exp_e  [64];

    always #10 clk = ~clk;

    mii_tx_serializer #(
        .MIN_LEN  (MINL),
        .MAX_LEN  (MAXL),
        .IFG_CLKS (IFG)
    ) u_mii_tx_serializer (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_data  (s_data),
        .s_err   (s_err),
        .s_last  (s_last),
        .s_ready (s_ready),
        .txd     (txd),
        .tx_en   (tx_en),
        .tx_er   (tx_er),
        .len_err (len_err)
    );

    // Record outputs once per clock, away from the rising edge.
    always @(negedge clk) begin
        if (cyc < LOGN) begin
            lg_en[cyc]  = tx_en;
            lg_d[cyc]   = txd;
            lg_er[cyc]  = tx_er;
            lg_rdy[cyc] = s_ready;
            lg_len[cyc] = len_err;
        end
        cyc = cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int i);
        return 8'(f * 37 + i * 11 + 3);
    endfunction

    // Offer n bytes; record the byte slots the block is expected to send.
    task automatic send_frame(input int f, input int n, input int errpos,
                              input int urpos, input bit keep, input int base,
                              output int nw);
        int i = 0;
        bit urd = 0;
        nw = 0;
        while (i < n) begin
            @(negedge clk);
            if (s_ready && i == urpos && !urd) begin
                s_valid = 1'b0;
                urd = 1;
                exp_b[base + nw] = 8'h00;
                exp_e[base + nw] = 1'b1;
                nw++;
            end else begin
                s_valid = 1'b1;
                s_data  = pat(f, i);
                s_err   = (i == errpos);
                s_last  = (i == n - 1);
                if (s_ready) begin
                    exp_b[base + nw] = s_data;
                    exp_e[base + nw] = s_err;
                    nw++;
                    i++;
                end
            end
        end
        if (!keep) begin
            @(negedge clk);
            s_valid = 1'b0;
            s_last  = 1'b0;
            s_err   = 1'b0;
        end
    endtask

    // Compare one logged burst against the expected nibble image.
    task automatic check_frame(input int base, input int nw, input string etag,
                               output int cs, output int ce);
        int c;
        int nbad;
        bit exp_len;
        exp_len = (nw < MINL) || (nw > MAXL);
        c = last_end;
        while (c < cyc - 1 && !lg_en[c]) c++;
        cs = c;
        ce = c + 16 + 2 * nw;
        chk(lg_en[c] == 1'b1, "R5 frame start found", int'(lg_en[c]), 1);
        nbad = 0;
        for (int k = 0; k < 15; k++)
            if (!lg_en[c + k] || lg_d[c + k] != 4'h5 || lg_er[c + k]) nbad++;
        chk(nbad == 0, "R2 preamble nibbles wrong", nbad, 0);
        chk(lg_en[c + 15] && lg_d[c + 15] == 4'hD, "R3 delimiter nibble", int'(lg_d[c + 15]), 13);
        nbad = 0;
        for (int j = 0; j < nw; j++) begin
            if (lg_d[c + 16 + 2 * j] != exp_b[base + j][3:0]) nbad++;
            if (lg_d[c + 17 + 2 * j] != exp_b[base + j][7:4]) nbad++;
        end
        chk(nbad == 0, "R4 payload nibbles wrong", nbad, 0);
        nbad = 0;
        for (int j = 0; j < nw; j++) begin
            bit ee;
            ee = exp_e[base + j] || (j + 1 > MAXL) || (j == nw - 1 && nw < MINL);
            if (lg_er[c + 16 + 2 * j] != ee) nbad++;
            if (lg_er[c + 17 + 2 * j] != ee) nbad++;
        end
        chk(nbad == 0, {etag, " tx_er marking wrong"}, nbad, 0);
        nbad = 0;
        for (int k = c; k < ce; k++) if (!lg_en[k]) nbad++;
        if (lg_en[ce] || lg_d[ce] != 4'h0 || lg_er[ce]) nbad++;
        chk(nbad == 0, "R5 tx_en window wrong", nbad, 0);
        nbad = 0;
        for (int k = c; k <= ce; k++) begin
            bit er;
            er = (k == c + 15);
            for (int j = 0; j < nw - 1; j++) if (k == c + 17 + 2 * j) er = 1;
            if (lg_rdy[k] != er) nbad++;
        end
        chk(nbad == 0, "R6 ready pattern wrong", nbad, 0);
        chk(lg_len[c + 15] == 1'b0, "R9 len_err not cleared at frame start", int'(lg_len[c + 15]), 0);
        chk(lg_len[ce] == exp_len, {etag, " len_err after frame"}, int'(lg_len[ce]), int'(exp_len));
        if (prev_end >= 0)
            chk(c - prev_end >= IFG, "R11 idle gap too short", c - prev_end, IFG);
        prev_end = ce;
        last_end = ce;
    endtask

    task automatic run_frame(input int f, input int n, input int errpos, input int urpos,
                             input string etag);
        int nw, cs, ce;
        send_frame(f, n, errpos, urpos, 1'b0, 0, nw);
        repeat (4) @(negedge clk);
        check_frame(0, nw, etag, cs, ce);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nw1, nw2, c1, e1, c2, e2, hi_cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!tx_en && !tx_er && txd == 4'h0 && !s_ready && !len_err,
            "R1 outputs after reset", int'({tx_en, tx_er, txd, s_ready, len_err}), 0);
        rst_n = 1'b1;
        // R12: idle with no valid
        repeat (2) @(negedge clk);
        c1 = cyc;
        repeat (40) @(negedge clk);
        hi_cnt = 0;
        for (int k = c1; k < cyc - 1; k++) if (lg_en[k] || lg_rdy[k]) hi_cnt++;
        chk(hi_cnt == 0, "R12 activity while idle", hi_cnt, 0);
        last_end = cyc - 1;
        // Length sweep: short, boundary, in range, over length
        for (int n = 1; n <= MAXL + 2; n++) begin
            if (n < MINL)       run_frame(n, n, -1, -1, "R9");
            else if (n == MINL) run_frame(n, n, -1, -1, "R9");
            else if (n <= MAXL) run_frame(n, n, -1, -1, (n == MAXL) ? "R10" : "R7");
            else                run_frame(n, n, -1, -1, "R10");
        end
        // R7: source error marks on first, middle and last bytes
        run_frame(20, 6, 2, -1, "R7");
        run_frame(21, 5, 0, -1, "R7");
        run_frame(22, 5, 4, -1, "R7");
        // R8: missing byte inside a frame, also forcing a short frame
        run_frame(23, 5, -1, 2, "R8");
        run_frame(24, 2, -1, 1, "R8");
        run_frame(25, 7, -1, 0, "R8");
        // R11: back-to-back frames with the next byte held valid
        send_frame(30, 4, -1, -1, 1'b1, 0, nw1);
        send_frame(31, 9, -1, -1, 1'b0, 32, nw2);
        repeat (4) @(negedge clk);
        check_frame(0, nw1, "R7", c1, e1);
        check_frame(32, nw2, "R10", c2, e2);
        chk(c2 - e1 == IFG, "R11 back-to-back gap", c2 - e1, IFG);
        // R1: reset in the middle of a long frame
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = 8'hA5;
        s_last  = 1'b0;
        repeat (60) @(negedge clk);
        chk(tx_en == 1'b1, "R1 frame running before reset", int'(tx_en), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!tx_en && !tx_er && txd == 4'h0 && !s_ready && !len_err,
            "R1 outputs after mid-frame reset", int'({tx_en, tx_er, txd, s_ready, len_err}), 0);
        s_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        last_end = cyc - 1;
        prev_end = -1;
        run_frame(40, MINL + 1, -1, -1, "R7");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule